// File: doc/BRIEF.md
# Asynchronous pseudo-SRAM access controller

This block sits between a synchronous host and a 4M x 16 pseudo-static RAM that has an asynchronous, SRAM-style pin interface. The host raises a request with a 22-bit word address, a read/write flag, 16 bits of write data and a two-bit byte-enable mask. It holds the request until a one-cycle acknowledge returns. The controller latches the request and plays out the active-low chip select, output enable, write enable and the two byte strobes. It also controls the enable of the data-bus drivers, and it captures read data on the clock edge that closes the read.

Every interval on the memory side is a whole number of system-clock cycles. Each count is worked out at elaboration from the clock period and the memory's nanosecond limits, rounded up. The default clock is 100 MHz, which gives these lengths:

| Phase | Default length |
|---|---|
| Read access | 7 cycles |
| Write pulse | 6 cycles |
| Write recovery | 1 cycle |
| Bus turnaround after a read | 2 cycles |

The state machine has five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | All strobes are high and the controller waits for a request. |
| `ST_READ` | Chip select and output enable are low. |
| `ST_TURN` | All strobes are high while the memory releases the bus. |
| `ST_WRITE` | Chip select and write enable are low, and the controller drives the bus. |
| `ST_RECOVER` | All strobes are high after a write. |

The transitions are:

- **accept-read:** `ST_IDLE` to `ST_READ`.
- **accept-write:** `ST_IDLE` to `ST_WRITE`.
- **read-done:** `ST_READ` to `ST_TURN`.
- **turn-done:** `ST_TURN` to `ST_IDLE`.
- **write-done:** `ST_WRITE` to `ST_RECOVER`.
- **recover-done:** `ST_RECOVER` to `ST_IDLE`.

Each transition fires when the phase timer reaches zero, except the two accept transitions, which fire on a request seen in `ST_IDLE`.

Top module: `psram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, chip select, output enable, write enable and both byte strobes are high, the bus drivers are disabled and acknowledge is low.
- R2: A read request (`we_i`=0) accepted at a clock edge holds chip select and output enable low, and write enable high, for exactly RD_CYC cycles (7 by default), starting at that edge.
- R3: Read data is captured at the edge that ends the read phase and appears on `rdata_o` from then on. Byte lanes whose enable bit is 0 read as zero. Bit 0 of `be_i` selects DQ[7:0] and bit 1 selects DQ[15:8].
- R4: A write request (`we_i`=1) holds chip select and write enable low, and output enable high, for exactly WR_CYC cycles (6 by default). During the same cycles the controller drives the latched write data on `mem_dq_o` with `mem_dq_oe_o`=1.
- R5: While a read or write is active, `mem_lb_n_o` is the inverse of `be_i[0]` and `mem_ub_n_o` is the inverse of `be_i[1]`. Both are high outside active phases.
- R6: Each request produces exactly one acknowledge pulse, one cycle wide. It falls in the first cycle after a read or write phase ends.
- R7: After a write, every strobe stays high for REC_CYC cycles (1 by default), so that a complete write lasts at least the minimum cycle time of 7 cycles.
- R8: After a read, every strobe stays high and the drivers stay off for HZ_CYC cycles (2 by default). The drivers are only ever on while output enable is high, and are off in the cycle before output enable falls.
- R9: Chip select never stays low for more than MAX_CYC consecutive cycles (1000 by default).
- R10: Address, write data and byte mask are latched at acceptance. The memory address does not change while chip select is low, even if the host inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, held by the host until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 = low byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data, disabled lanes zero |
| mem_addr_o | output | 22 | Memory address |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_lb_n_o | output | 1 | Low-byte strobe, active low |
| mem_ub_n_o | output | 1 | High-byte strobe, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the data-bus drivers |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The assertions assume that the host keeps `req_i` high until it sees `ack_o`, and drops it at the next clock edge. A request still high in `ST_IDLE` would otherwise start a second access. The bench follows this handshake in every transaction. The bench also changes the address, data and mask inputs right after acceptance, so the latching is exercised. Its memory model returns junk data until chip select and output enable have both been low for the full access time, so an early capture shows up as a wrong value.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WRITE,
        ST_RECOVER
    } ctrl_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 22,
    parameter int DATA_W          = 16,
    parameter int CLK_PERIOD_NS   = 10,
    parameter int T_CYCLE_MIN_NS  = 70,
    parameter int T_ACCESS_NS     = 70,
    parameter int T_WR_PULSE_NS   = 50,
    parameter int T_WR_END_NS     = 60,
    parameter int T_DATA_SETUP_NS = 20,
    parameter int T_BUS_FLOAT_NS  = 20,
    parameter int T_CYCLE_MAX_NS  = 10000,
    localparam int LANES          = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  be_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic              mem_lb_n_o,
    output logic              mem_ub_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int RD_CYC  = imax(cdiv(T_ACCESS_NS, CLK_PERIOD_NS),
                                  cdiv(T_CYCLE_MIN_NS, CLK_PERIOD_NS));
    localparam int WR_CYC  = imax(cdiv(T_WR_PULSE_NS, CLK_PERIOD_NS),
                             imax(cdiv(T_WR_END_NS, CLK_PERIOD_NS),
                                  cdiv(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
    localparam int REC_CYC = imax(1, cdiv(T_CYCLE_MIN_NS, CLK_PERIOD_NS) - WR_CYC);
    localparam int HZ_CYC  = imax(1, cdiv(T_BUS_FLOAT_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC = T_CYCLE_MAX_NS / CLK_PERIOD_NS;
    localparam int LONGEST = imax(imax(RD_CYC, WR_CYC), imax(REC_CYC, HZ_CYC));
    localparam int CNT_W   = $clog2(LONGEST + 1);

    ctrl_state_e       state_q, state_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;
    logic              accept;
    logic              phase_end;

    psram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
    end

    // next-state logic and phase timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_i) begin
                state_d  = we_i ? ST_WRITE : ST_READ;
                tmr_load = 1'b1;
                tmr_val  = we_i ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
            ST_READ: if (tmr_done) begin
                state_d  = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HZ_CYC - 1);
            end
            ST_TURN: if (tmr_done) state_d = ST_IDLE;
            ST_WRITE: if (tmr_done) begin
                state_d  = ST_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
            end
            ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept    = (state_q == ST_IDLE) && req_i;
    assign phase_end = tmr_done && (state_q == ST_READ || state_q == ST_WRITE);

    // state register and request-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= phase_end;
            if (accept) begin
                addr_q  <= addr_i;
                wdata_q <= wdata_i;
                be_q    <= be_i;
            end
            if (state_q == ST_READ && tmr_done) begin
                rdata_q <= mem_dq_i & lane_mask;
            end
        end
    end

    // memory-side strobe decode
    always_comb begin
        mem_cs_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_we_n_o  = 1'b1;
        mem_lb_n_o  = 1'b1;
        mem_ub_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        unique case (state_q)
            ST_READ: begin
                mem_cs_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
                mem_lb_n_o = ~be_q[0];
                mem_ub_n_o = ~be_q[LANES-1];
            end
            ST_WRITE: begin
                mem_cs_n_o  = 1'b0;
                mem_we_n_o  = 1'b0;
                mem_lb_n_o  = ~be_q[0];
                mem_ub_n_o  = ~be_q[LANES-1];
                mem_dq_oe_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wdata_q;
    assign ack_o      = ack_q;
    assign rdata_o    = rdata_q;
endmodule

// File: rtl/psram_async_ctrl_chk.sv
module psram_async_ctrl_chk #(
    parameter int ADDR_W  = 22,
    parameter int RD_CYC  = 7,
    parameter int WR_CYC  = 6,
    parameter int HZ_CYC  = 2,
    parameter int MAX_CYC = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_cs_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_we_n_o,
    input logic              mem_dq_oe_o
);
    int unsigned we_low_cnt, oe_low_cnt, oe_high_cnt, cs_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt  <= 0;
            oe_low_cnt  <= 0;
            oe_high_cnt <= HZ_CYC;
            cs_low_cnt  <= 0;
        end else begin
            we_low_cnt  <= mem_we_n_o ? 0 : we_low_cnt + 1;
            oe_low_cnt  <= mem_oe_n_o ? 0 : oe_low_cnt + 1;
            cs_low_cnt  <= mem_cs_n_o ? 0 : cs_low_cnt + 1;
            if (!mem_oe_n_o)                 oe_high_cnt <= 0;
            else if (oe_high_cnt < HZ_CYC)   oe_high_cnt <= oe_high_cnt + 1;
        end
    end

    // R2
    read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n_o) |-> (oe_low_cnt == RD_CYC));

    // R4
    write_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_low_cnt == WR_CYC));

    // R4
    write_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_cs_n_o && mem_oe_n_o));

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R8
    drive_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (oe_high_cnt >= HZ_CYC));

    // R8
    release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));

    // R9
    stretch_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_low_cnt <= MAX_CYC);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));
endmodule

bind psram_async_ctrl psram_async_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .HZ_CYC  (HZ_CYC),
    .MAX_CYC (MAX_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_o       (ack_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/psram_async_ctrl_bench.sv
module psram_async_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RD_LEN     = 7;
    localparam int WR_LEN     = 6;
    localparam int REC_LEN    = 1;
    localparam int HZ_LEN     = 2;
    localparam int MAX_LOW    = 1000;

    typedef struct {
        bit          cs_n, oe_n, we_n, lb_n, ub_n, dq_oe, ack, is_rd;
        logic [21:0] addr;
        logic [15:0] wdata, rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [21:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [1:0]  be_i = '0;
    logic        ack_o;
    logic [15:0] rdata_o;
    logic [21:0] mem_addr_o;
    logic        mem_cs_n_o, mem_oe_n_o, mem_we_n_o, mem_lb_n_o, mem_ub_n_o;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe_o;
    logic [15:0] mem_dq_i = 16'hDEAD;

    int tests = 0, fails = 0;
    int acc_cnt = 0, low_run = 0, low_max = 0;
    bit run_checks = 1'b0;
    exp_t exp_q[$];
    logic [15:0] mem_arr  [logic [21:0]];
    logic [15:0] shadow   [logic [21:0]];

    psram_async_ctrl u_psram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .be_i(be_i), .ack_o(ack_o), .rdata_o(rdata_o),
        .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_we_n_o(mem_we_n_o), .mem_lb_n_o(mem_lb_n_o), .mem_ub_n_o(mem_ub_n_o),
        .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] init_word(input logic [21:0] a);
        return a[15:0] ^ 16'h3C5A;
    endfunction

    function automatic exp_t idle_entry(input string tag);
        exp_t e;
        e.cs_n = 1; e.oe_n = 1; e.we_n = 1; e.lb_n = 1; e.ub_n = 1;
        e.dq_oe = 0; e.ack = 0; e.is_rd = 0;
        e.addr = '0; e.wdata = '0; e.rdata = '0; e.tag = tag;
        return e;
    endfunction

    task automatic chk(input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // memory model and cycle-by-cycle comparison
    always @(negedge clk) begin
        exp_t e;
        logic [15:0] word;
        if (!mem_cs_n_o && !mem_we_n_o && mem_dq_oe_o) begin
            word = mem_arr.exists(mem_addr_o) ? mem_arr[mem_addr_o] : init_word(mem_addr_o);
            if (!mem_lb_n_o) word[7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n_o) word[15:8] = mem_dq_o[15:8];
            mem_arr[mem_addr_o] = word;
        end
        if (!mem_cs_n_o && !mem_oe_n_o) acc_cnt++; else acc_cnt = 0;
        if (acc_cnt >= RD_LEN) begin
            word = mem_arr.exists(mem_addr_o) ? mem_arr[mem_addr_o] : init_word(mem_addr_o);
            if (mem_lb_n_o) word[7:0]  = 8'hEE;
            if (mem_ub_n_o) word[15:8] = 8'hEE;
            mem_dq_i = word;
        end else begin
            mem_dq_i = 16'hDEAD;
        end
        if (!mem_cs_n_o) low_run++; else low_run = 0;
        if (low_run > low_max) low_max = low_run;

        if (run_checks) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_entry("R7");
            chk(e.tag, "cs_n", mem_cs_n_o, e.cs_n);
            chk(e.tag, "oe_n", mem_oe_n_o, e.oe_n);
            chk(e.tag, "we_n", mem_we_n_o, e.we_n);
            chk("R5", "lb_n", mem_lb_n_o, e.lb_n);
            chk("R5", "ub_n", mem_ub_n_o, e.ub_n);
            chk("R8", "dq_oe", mem_dq_oe_o, e.dq_oe);
            chk("R6", "ack", ack_o, e.ack);
            if (!e.cs_n)  chk("R10", "addr", mem_addr_o, e.addr);
            if (e.dq_oe)  chk("R4", "dq_o", mem_dq_o, e.wdata);
            if (e.ack && e.is_rd) chk("R3", "rdata", rdata_o, e.rdata);
        end
    end

    task automatic access(input bit wr, input logic [21:0] a,
                          input logic [15:0] d, input logic [1:0] be);
        exp_t e;
        logic [15:0] word;
        int k;
        @(posedge clk); #1;
        req_i = 1'b1; we_i = wr; addr_i = a; wdata_i = d; be_i = be;
        exp_q.push_back(idle_entry("R2"));
        word = shadow.exists(a) ? shadow[a] : init_word(a);
        if (wr) begin
            for (int i = 0; i < WR_LEN; i++) begin
                e = idle_entry("R4");
                e.cs_n = 0; e.we_n = 0; e.lb_n = !be[0]; e.ub_n = !be[1];
                e.dq_oe = 1; e.addr = a; e.wdata = d;
                exp_q.push_back(e);
            end
            for (int i = 0; i < REC_LEN; i++) begin
                e = idle_entry("R7");          // R7 recovery with strobes high
                e.ack = (i == 0);
                exp_q.push_back(e);
            end
            if (be[0]) word[7:0]  = d[7:0];
            if (be[1]) word[15:8] = d[15:8];
            shadow[a] = word;
            k = WR_LEN + 1;
        end else begin
            for (int i = 0; i < RD_LEN; i++) begin
                e = idle_entry("R2");
                e.cs_n = 0; e.oe_n = 0; e.lb_n = !be[0]; e.ub_n = !be[1];
                e.addr = a;
                exp_q.push_back(e);
            end
            for (int i = 0; i < HZ_LEN; i++) begin
                e = idle_entry("R8");
                e.ack = (i == 0); e.is_rd = 1;
                e.rdata = word & {{8{be[1]}}, {8{be[0]}}};
                exp_q.push_back(e);
            end
            k = RD_LEN + 1;
        end
        @(posedge clk); #1;
        addr_i = ~a; wdata_i = ~d; be_i = ~be;   // R10 inputs move after acceptance
        repeat (k) @(posedge clk);
        #1 req_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", mem_cs_n_o, 1); chk("R1", "oe_n", mem_oe_n_o, 1);
        chk("R1", "we_n", mem_we_n_o, 1); chk("R1", "lb_n", mem_lb_n_o, 1);
        chk("R1", "ub_n", mem_ub_n_o, 1); chk("R1", "dq_oe", mem_dq_oe_o, 0);
        chk("R1", "ack", ack_o, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        run_checks = 1'b1;
        repeat (3) @(posedge clk);

        access(1'b1, 22'h000000, 16'h1234, 2'b11);
        access(1'b0, 22'h000000, 16'h0000, 2'b11);
        access(1'b1, 22'h3FFFFF, 16'hABCD, 2'b01);
        access(1'b0, 22'h3FFFFF, 16'h0000, 2'b11);
        access(1'b1, 22'h3FFFFF, 16'h9900, 2'b10);
        access(1'b0, 22'h3FFFFF, 16'h0000, 2'b11);
        access(1'b0, 22'h3FFFFF, 16'h0000, 2'b01);
        access(1'b0, 22'h3FFFFF, 16'h0000, 2'b10);
        access(1'b0, 22'h12345A, 16'h0000, 2'b11);
        access(1'b1, 22'h12345A, 16'hFFFF, 2'b00);
        access(1'b0, 22'h12345A, 16'h0000, 2'b11);
        access(1'b1, 22'h0ABCDE, 16'h5A5A, 2'b11);
        access(1'b1, 22'h0ABCDE, 16'hC3C3, 2'b10);
        access(1'b0, 22'h0ABCDE, 16'h0000, 2'b11);
        repeat (6) @(posedge clk);
        // R9 longest chip-select low run
        tests++;
        if (low_max > MAX_LOW) begin
            fails++;
            $display("FAIL R9 cs low run actual=%0d expected<=%0d", low_max, MAX_LOW);
        end
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R6 pending expectations actual=%0d expected=0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule